// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one access to a single-lane serial flash device for each command word that software writes. An access is made of up to four phases in fixed order: an 8-bit opcode, 0 to 3 address bytes, 0 to 15 dummy bytes and 0 to 4 data bytes. Software first loads an address register and a 32-bit data register, then writes the command word. Data bytes are either sent from the data register or received into it, never both in one command. A status register reports a running command and a sticky error.

A keep-select flag in the command word leaves the chip select asserted when the command completes. A follow-on command then skips its opcode and continues the same flash transaction, so one long flash sequence can be split over several commands. Serial clock timing comes from a small tick generator. The bus uses clock mode 3: the clock idles high, the block changes its output on falling edges and samples its input on rising edges.

Registers are reached through a simple select/strobe port. The select codes are 0 command, 1 address, 2 data, 3 status and 4 line control. A read returns data one clock after the read strobe.

Top module: `sfc_engine`

## Requirements
- R1: The command word holds opcode in bits 7:0, write direction in bit 8, data length in bits 11:9, keep-select in bit 15, dummy length in bits 19:16, address length in bits 22:20 and chip-select index in bits 26:24. When no select is held, the command starts with its opcode, sent MSB first.
- R2: After the opcode, the block sends the number of address bytes given by the address length (0 to 3; larger values act as 3), taken from the low bytes of the address register, most significant byte first.
- R3: The dummy phase sends as many all-zero bytes as the dummy length (0 to 15).
- R4: A write command sends the data length in bytes (0 to 4; larger values act as 4) from the data register, bits 7:0 first, each byte MSB first.
- R5: A read command drives MOSI low during its data phase. It places the first received byte in data bits 7:0, the next in 15:8 and so on, and clears the data bytes it does not receive.
- R6: With keep-select set, the chip select stays asserted after the command. The next command reuses that select and skips its opcode phase.
- R7: A command with address, dummy and data length all 0 and keep-select clear, written while a select is held, releases the select without any clock edge.
- R8: Status bit 22 reads 1 from the clock after a command is accepted until the command is complete. Received data is valid in the data register once the bit reads 0.
- R9: A command write while bit 22 is 1 is dropped and sets status bit 29. Bit 29 stays set until software writes the status register with bit 29 at 1.
- R10: SCK idles high and toggles only on ticks of the timing generator. MOSI changes on falling edges and MISO is sampled on rising edges. At most one chip-select line, the one named by the index field, is low.
- R11: The line control register resets to 4'b1100. Its bit 3 drives the HOLD line and its bit 2 drives the WP line, both active low.
- R12: Writes to the address or data register while bit 22 is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_sel | input | 3 | Register select: 0 command, 1 address, 2 data, 3 status, 4 line control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid one clock after cfg_re |
| sf_sck | output | 1 | Serial clock, idles high |
| sf_cs_n | output | NCS | Active-low chip selects |
| sf_mosi | output | 1 | Serial data to the flash |
| sf_miso | input | 1 | Serial data from the flash |
| sf_wp_n | output | 1 | Write-protect line, from line control bit 2 |
| sf_hold_n | output | 1 | Hold line, from line control bit 3 |

## Verification
The assertions assume that software uses the port one register access per clock and never writes and reads in the same cycle. They also assume the flash model returns MISO bits only while a chip select is low. The directed bench keeps to this: each task raises one strobe at a falling clock edge and drops it one clock later. The flash model drives MISO only on falling SCK edges with a select asserted, and records MOSI only on rising edges. The error scenario is the only one that writes registers while a command is running, and it does so on purpose.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  localparam int WR_BIT   = 8;
  localparam int KEEP_BIT = 15;
  localparam int PEND_BIT = 22;
  localparam int ERR_BIT  = 29;

  typedef enum logic [2:0] {
    SEL_CMD = 3'd0, SEL_ADDR = 3'd1, SEL_DATA = 3'd2, SEL_STAT = 3'd3, SEL_IOCTL = 3'd4
  } sel_e;

  typedef enum logic [2:0] {PH_OPC, PH_ADR, PH_DUM, PH_DAT, PH_NONE} phase_e;

  typedef struct packed {
    logic [7:0] opc;
    logic       wr;
    logic [2:0] dlen;
    logic       keep;
    logic [3:0] dum;
    logic [1:0] alen;
    logic [2:0] csi;
  } cmd_t;

  function automatic cmd_t decode_cmd(logic [31:0] w);
    cmd_t c;
    c.opc  = w[7:0];
    c.wr   = w[WR_BIT];
    c.dlen = (w[11:9] > 3'd4) ? 3'd4 : w[11:9];
    c.keep = w[KEEP_BIT];
    c.dum  = w[19:16];
    c.alen = (w[22:20] > 3'd3) ? 2'd3 : w[21:20];
    c.csi  = w[26:24];
    return c;
  endfunction

  // next non-empty phase following p
  function automatic phase_e next_after(phase_e p, logic [1:0] al, logic [3:0] du, logic [2:0] dl);
    phase_e n;
    n = PH_NONE;
    if (p == PH_OPC && al != 2'd0) n = PH_ADR;
    else if ((p == PH_OPC || p == PH_ADR) && du != 4'd0) n = PH_DUM;
    else if (p != PH_DAT && p != PH_NONE && dl != 3'd0) n = PH_DAT;
    return n;
  endfunction

  function automatic logic [3:0] phase_len(phase_e p, logic [1:0] al, logic [3:0] du, logic [2:0] dl);
    case (p)
      PH_OPC:  return 4'd1;
      PH_ADR:  return {2'b00, al};
      PH_DUM:  return du;
      PH_DAT:  return {1'b0, dl};
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [7:0] fetch_byte(phase_e p, logic [3:0] idx, logic [7:0] opc,
                                            logic [1:0] al, logic [23:0] addr,
                                            logic [31:0] data, logic wr);
    logic [1:0]  s;
    logic [31:0] t;
    s = al - 2'd1 - idx[1:0];
    t = data >> {idx[1:0], 3'b000};
    case (p)
      PH_OPC: return opc;
      PH_ADR: begin
        case (s)
          2'd0:    return addr[7:0];
          2'd1:    return addr[15:8];
          default: return addr[23:16];
        endcase
      end
      PH_DAT:  return wr ? t[7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sfc_tick_gen.sv
`timescale 1ns/1ps
module sfc_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sfc_regs.sv
`timescale 1ns/1ps
module sfc_regs
  import sfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic        re,
  input  logic [2:0]  sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        busy,
  input  logic        rx_we,
  input  logic [1:0]  rx_idx,
  input  logic [7:0]  rx_byte,
  output logic        start,
  output logic [23:0] addr_q,
  output logic [31:0] data_q,
  output logic        err,
  output logic        wp_n,
  output logic        hold_n
);
  logic [31:0] cmd_last;
  logic [3:0]  ioc;
  logic        cmd_wr;
  cmd_t        wcmd;

  assign cmd_wr = we && (sel == SEL_CMD);
  assign start  = cmd_wr && !busy;
  assign wcmd   = decode_cmd(wdata);
  assign wp_n   = ioc[2];
  assign hold_n = ioc[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_last <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      ioc      <= 4'b1100;
      err      <= 1'b0;
      rdata    <= '0;
    end else begin
      if (start) cmd_last <= wdata;

      if (cmd_wr && busy) err <= 1'b1;
      else if (we && sel == SEL_STAT && wdata[ERR_BIT]) err <= 1'b0;

      if (we && sel == SEL_ADDR && !busy) addr_q <= wdata[23:0];

      if (we && sel == SEL_DATA && !busy) data_q <= wdata;
      else if (start && !wcmd.wr && wcmd.dlen != 3'd0) data_q <= '0;
      else if (rx_we) data_q[{rx_idx, 3'b000} +: 8] <= rx_byte;

      if (we && sel == SEL_IOCTL) ioc <= wdata[3:0];

      if (re) begin
        case (sel)
          SEL_CMD:   rdata <= cmd_last;
          SEL_ADDR:  rdata <= {8'h00, addr_q};
          SEL_DATA:  rdata <= data_q;
          SEL_STAT: begin
            rdata           <= '0;
            rdata[PEND_BIT] <= busy;
            rdata[ERR_BIT]  <= err;
          end
          SEL_IOCTL: rdata <= {28'h0, ioc};
          default:   rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfc_seq.sv
`timescale 1ns/1ps
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int NCS = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [31:0]    cmd_word,
  input  logic [23:0]    addr,
  input  logic [31:0]    data,
  input  logic           tick,
  input  logic           miso,
  output logic           busy,
  output logic           sck,
  output logic           mosi,
  output logic [NCS-1:0] cs_n,
  output logic           rx_we,
  output logic [1:0]     rx_idx,
  output logic [7:0]     rx_byte
);
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} st_e;

  st_e        st;
  cmd_t       cur, nc;
  phase_e     ph, first_ph, nxt_ph;
  logic [3:0] bidx;
  logic [2:0] bitc;
  logic [7:0] shreg, rxsh, rx_full;
  logic       cs_on, cs_held, last_in_phase, rel_only;
  logic [2:0] cs_idx;

  assign nc   = decode_cmd(cmd_word);
  assign busy = (st != ST_IDLE);

  always_comb begin
    first_ph      = cs_held ? next_after(PH_OPC, nc.alen, nc.dum, nc.dlen) : PH_OPC;
    rel_only      = cs_held && nc.alen == 2'd0 && nc.dum == 4'd0 && nc.dlen == 3'd0 && !nc.keep;
    last_in_phase = (bidx + 4'd1) >= phase_len(ph, cur.alen, cur.dum, cur.dlen);
    nxt_ph        = next_after(ph, cur.alen, cur.dum, cur.dlen);
    rx_full       = {rxsh[6:0], miso};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cur     <= '0;
      ph      <= PH_OPC;
      bidx    <= '0;
      bitc    <= '0;
      shreg   <= '0;
      rxsh    <= '0;
      sck     <= 1'b1;
      mosi    <= 1'b0;
      cs_on   <= 1'b0;
      cs_held <= 1'b0;
      cs_idx  <= '0;
      rx_we   <= 1'b0;
      rx_idx  <= '0;
      rx_byte <= '0;
    end else begin
      rx_we <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (rel_only) begin
              cs_on   <= 1'b0;
              cs_held <= 1'b0;
            end else begin
              cur   <= nc;
              cs_on <= 1'b1;
              mosi  <= 1'b0;
              bitc  <= '0;
              bidx  <= '0;
              ph    <= first_ph;
              if (!cs_held) cs_idx <= nc.csi;
              shreg <= fetch_byte(first_ph, 4'd0, nc.opc, nc.alen, addr, data, nc.wr);
              st    <= (first_ph == PH_NONE) ? ST_TAIL : ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (sck) begin
              sck  <= 1'b0;
              mosi <= shreg[7];
            end else begin
              sck   <= 1'b1;
              rxsh  <= rx_full;
              shreg <= {shreg[6:0], 1'b0};
              bitc  <= bitc + 3'd1;
              if (bitc == 3'd7) begin
                if (ph == PH_DAT && !cur.wr) begin
                  rx_we   <= 1'b1;
                  rx_idx  <= bidx[1:0];
                  rx_byte <= rx_full;
                end
                if (!last_in_phase) begin
                  bidx  <= bidx + 4'd1;
                  shreg <= fetch_byte(ph, bidx + 4'd1, cur.opc, cur.alen, addr, data, cur.wr);
                end else begin
                  bidx  <= '0;
                  ph    <= nxt_ph;
                  shreg <= fetch_byte(nxt_ph, 4'd0, cur.opc, cur.alen, addr, data, cur.wr);
                  if (nxt_ph == PH_NONE) st <= ST_TAIL;
                end
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_on   <= cur.keep;
            cs_held <= cur.keep;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cs_n[g] <= 1'b1;
      else     cs_n[g] <= !(cs_on && cs_idx == 3'(g));
    end
  end
endmodule

// File: rtl/sfc_engine.sv
`timescale 1ns/1ps
module sfc_engine #(
  parameter int NCS      = 8,
  parameter int HALF_DIV = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic           cfg_re,
  input  logic [2:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  output logic           sf_sck,
  output logic [NCS-1:0] sf_cs_n,
  output logic           sf_mosi,
  input  logic           sf_miso,
  output logic           sf_wp_n,
  output logic           sf_hold_n
);
  logic        busy, tick, start, err, rx_we;
  logic [1:0]  rx_idx;
  logic [7:0]  rx_byte;
  logic [23:0] addr_q;
  logic [31:0] data_q;

  sfc_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .re(cfg_re), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .busy(busy), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .start(start), .addr_q(addr_q), .data_q(data_q), .err(err),
    .wp_n(sf_wp_n), .hold_n(sf_hold_n)
  );

  sfc_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .en(busy), .tick(tick)
  );

  sfc_seq #(.NCS(NCS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cmd_word(cfg_wdata), .addr(addr_q), .data(data_q),
    .tick(tick), .miso(sf_miso), .busy(busy), .sck(sf_sck), .mosi(sf_mosi), .cs_n(sf_cs_n),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/sfc_engine_sva.sv
`timescale 1ns/1ps
module sfc_engine_sva #(
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           tick,
  input logic           err,
  input logic           sck,
  input logic [NCS-1:0] cs_n,
  input logic           we,
  input logic [2:0]     sel,
  input logic [31:0]    wdata
);
  a_r10_sck_idle_high: assert property (@(posedge clk) disable iff (rst) !busy |-> sck);
  a_r10_sck_only_on_tick: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(sck));
  a_r10_one_select: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));
  a_r6_select_while_clocking: assert property (@(posedge clk) disable iff (rst)
    (busy && !sck) |-> (cs_n != {NCS{1'b1}}));
  a_r9_busy_write_flags: assert property (@(posedge clk) disable iff (rst)
    (we && sel == 3'd0 && busy) |=> err);
  a_r9_error_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && !(we && sel == 3'd3 && wdata[29])) |=> err);
endmodule

bind sfc_engine sfc_engine_sva #(.NCS(NCS)) u_sva (
  .clk(clk), .rst(rst), .busy(busy), .tick(tick), .err(err), .sck(sf_sck), .cs_n(sf_cs_n),
  .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata)
);

// File: tb/sfc_engine_tb.sv
`timescale 1ns/1ps
module sfc_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sf_sck, sf_mosi, sf_wp_n, sf_hold_n;
  logic        sf_miso = 1'b0;
  logic [7:0]  sf_cs_n;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sfc_engine #(.NCS(8), .HALF_DIV(2)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sf_sck(sf_sck), .sf_cs_n(sf_cs_n),
    .sf_mosi(sf_mosi), .sf_miso(sf_miso), .sf_wp_n(sf_wp_n), .sf_hold_n(sf_hold_n)
  );

  // flash model: records MOSI on rising SCK, drives MISO on falling SCK
  logic [7:0] rec  [32];
  logic [7:0] resp [32];
  int rise_cnt = 0;

  always @(posedge sf_sck) begin
    if (sf_cs_n != 8'hFF && rise_cnt < 256) begin
      rec[rise_cnt / 8][7 - (rise_cnt % 8)] = sf_mosi;
      rise_cnt++;
    end
  end

  always @(negedge sf_sck) begin
    if (sf_cs_n != 8'hFF) sf_miso = resp[(rise_cnt / 8) % 32][7 - (rise_cnt % 8)];
  end

  task automatic clear_cap();
    rise_cnt = 0;
    for (int i = 0; i < 32; i++) begin
      rec[i]  = 8'h00;
      resp[i] = 8'h00;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] sel, output logic [31:0] v);
    @(negedge clk);
    cfg_re = 1'b1; cfg_sel = sel;
    @(negedge clk);
    cfg_re = 1'b0;
    v = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(3'd3, v);
      if (!v[22]) break;
    end
  endtask

  function automatic logic [31:0] mkcmd(logic [7:0] opc, logic wr, logic [2:0] dlen, logic keep,
                                        logic [3:0] dum, logic [2:0] alen, logic [2:0] csi);
    return {5'b0, csi, 1'b0, alen, dum, keep, 3'b0, dlen, wr, opc};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(3'd3, v);  check("R8 status after reset", v, 32'h0);
    rd_reg(3'd4, v);  check("R11 line control reset", v, 32'hC);
    check("R11 hold/wp idle", {30'b0, sf_hold_n, sf_wp_n}, 32'h3);
    check("R10 selects idle", {24'b0, sf_cs_n}, 32'hFF);
    check("R10 sck idles high", {31'b0, sf_sck}, 32'h1);
  endtask

  task automatic t_opcode_only();
    clear_cap();
    wr_reg(3'd0, mkcmd(8'h06, 1'b1, 3'd0, 1'b0, 4'd0, 3'd0, 3'd2));
    repeat (10) @(negedge clk);
    check("R10 select index 2", {24'b0, sf_cs_n}, 32'hFB);
    wait_idle();
    check("R1 opcode edge count", rise_cnt, 8);
    check("R1 opcode byte", {24'b0, rec[0]}, 32'h06);
    check("R6 release without keep", {24'b0, sf_cs_n}, 32'hFF);
  endtask

  task automatic t_write();
    clear_cap();
    wr_reg(3'd1, 32'hAB123456);
    wr_reg(3'd2, 32'h00CCBBAA);
    wr_reg(3'd0, mkcmd(8'h02, 1'b1, 3'd3, 1'b0, 4'd0, 3'd3, 3'd0));
    wait_idle();
    check("R1 write opcode", {24'b0, rec[0]}, 32'h02);
    check("R2 address MSB first", {8'b0, rec[1], rec[2], rec[3]}, 32'h123456);
    check("R4 write data LSB first", {8'b0, rec[6], rec[5], rec[4]}, 32'hCCBBAA);
    check("R4 write edge count", rise_cnt, 56);
  endtask

  task automatic t_read();
    logic [31:0] v;
    clear_cap();
    resp[5] = 8'h11; resp[6] = 8'h22; resp[7] = 8'h33; resp[8] = 8'h44;
    wr_reg(3'd2, 32'hDEADBEEF);
    wr_reg(3'd0, mkcmd(8'h0B, 1'b0, 3'd4, 1'b0, 4'd1, 3'd3, 3'd1));
    rd_reg(3'd3, v);
    check("R8 pending while running", {31'b0, v[22]}, 32'h1);
    wait_idle();
    rd_reg(3'd2, v);
    check("R5 read packing", v, 32'h44332211);
    check("R3 dummy byte zero", {24'b0, rec[4]}, 32'h0);
    check("R5 MOSI low in read data", {rec[5], rec[6], rec[7], rec[8]}, 32'h0);
    check("R5 read edge count", rise_cnt, 72);
  endtask

  task automatic t_read_short();
    logic [31:0] v;
    clear_cap();
    resp[1] = 8'h5A; resp[2] = 8'hA5;
    wr_reg(3'd2, 32'hFFFFFFFF);
    wr_reg(3'd0, mkcmd(8'h03, 1'b0, 3'd2, 1'b0, 4'd0, 3'd0, 3'd0));
    wait_idle();
    rd_reg(3'd2, v);
    check("R5 short read upper bytes cleared", v, 32'h0000A55A);
  endtask

  task automatic t_dummy15();
    logic [7:0] acc;
    clear_cap();
    wr_reg(3'd1, 32'h00000077);
    wr_reg(3'd2, 32'h00000099);
    wr_reg(3'd0, mkcmd(8'h5A, 1'b1, 3'd1, 1'b0, 4'd15, 3'd1, 3'd0));
    wait_idle();
    acc = 8'h00;
    for (int i = 2; i < 17; i++) acc = acc | rec[i];
    check("R2 single address byte", {24'b0, rec[1]}, 32'h77);
    check("R3 fifteen zero dummy bytes", {24'b0, acc}, 32'h0);
    check("R3 dummy edge count", rise_cnt, 144);
    check("R4 data after dummies", {24'b0, rec[17]}, 32'h99);
  endtask

  task automatic t_clamp();
    clear_cap();
    wr_reg(3'd2, 32'h44332211);
    wr_reg(3'd0, mkcmd(8'h32, 1'b1, 3'd7, 1'b0, 4'd0, 3'd0, 3'd0));
    wait_idle();
    check("R4 length above 4 acts as 4", rise_cnt, 40);
    check("R4 clamped bytes", {rec[4], rec[3], rec[2], rec[1]}, 32'h44332211);
  endtask

  task automatic t_keep();
    logic [31:0] v;
    clear_cap();
    wr_reg(3'd0, mkcmd(8'h9F, 1'b0, 3'd0, 1'b1, 4'd0, 3'd0, 3'd5));
    wait_idle();
    check("R6 select held after keep", {24'b0, sf_cs_n}, 32'hDF);
    check("R6 first command edges", rise_cnt, 8);
    resp[1] = 8'hC2; resp[2] = 8'h20; resp[3] = 8'h18;
    wr_reg(3'd0, mkcmd(8'hEE, 1'b0, 3'd3, 1'b1, 4'd0, 3'd0, 3'd1));
    wait_idle();
    check("R6 opcode skipped", rise_cnt, 32);
    rd_reg(3'd2, v);
    check("R6 continued read data", v, 32'h001820C2);
    check("R6 held select reused", {24'b0, sf_cs_n}, 32'hDF);
    wr_reg(3'd0, 32'h0);
    repeat (4) @(negedge clk);
    check("R7 release-only frees select", {24'b0, sf_cs_n}, 32'hFF);
    check("R7 release-only no clock", rise_cnt, 32);
  endtask

  task automatic t_busy_err();
    logic [31:0] v;
    clear_cap();
    wr_reg(3'd1, 32'h00654321);
    wr_reg(3'd2, 32'h12345678);
    wr_reg(3'd0, mkcmd(8'hAB, 1'b1, 3'd0, 1'b0, 4'd15, 3'd0, 3'd0));
    wr_reg(3'd0, mkcmd(8'hC7, 1'b1, 3'd0, 1'b0, 4'd0, 3'd0, 3'd0));
    wr_reg(3'd2, 32'h0BADF00D);
    wr_reg(3'd1, 32'h00AAAAAA);
    wait_idle();
    rd_reg(3'd3, v);
    check("R9 error set by busy write", {31'b0, v[29]}, 32'h1);
    check("R9 second command dropped", rise_cnt, 128);
    rd_reg(3'd2, v);
    check("R12 data write ignored while busy", v, 32'h12345678);
    rd_reg(3'd1, v);
    check("R12 address write ignored while busy", v, 32'h00654321);
    wr_reg(3'd3, 32'h20000000);
    rd_reg(3'd3, v);
    check("R9 error cleared by write-one", v, 32'h0);
  endtask

  task automatic t_ioctl();
    logic [31:0] v;
    wr_reg(3'd4, 32'h0);
    check("R11 hold/wp driven low", {30'b0, sf_hold_n, sf_wp_n}, 32'h0);
    wr_reg(3'd4, 32'h8);
    check("R11 bit3 hold bit2 wp", {30'b0, sf_hold_n, sf_wp_n}, 32'h2);
    wr_reg(3'd4, 32'hC);
    rd_reg(3'd4, v);
    check("R11 line control readback", v, 32'hC);
  endtask

  initial begin
    clear_cap();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_opcode_only();
    t_write();
    t_read();
    t_read_short();
    t_dummy15();
    t_clamp();
    t_keep();
    t_busy_err();
    t_ioctl();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule